// File: doc/BRIEF.md
# NaN Selection and Quieting Unit

This combinational unit sits beside a floating-point datapath and settles what a two- or three-input operation returns when one or more of its inputs is Not-a-Number. It examines up to three operands in single or double precision. It reports whether any participating operand is a NaN and whether any of them is a signaling NaN, which is an invalid-operation exception. It also produces the NaN the operation must return, always in quiet form.

The arithmetic pipeline computes its ordinary result in parallel. It then uses `nan_seen` to choose between that result and `nan_result`. Fused multiply-add style operations assert `use_three`. Plain two-input operations leave it low, and operand `opd_c` then takes no part in the result.

The selection favours signaling NaNs over quiet ones. Within each class it favours the later operand. The unit has no clock and no state. Every output follows the inputs within the same cycle.

Top module: `nan_select_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction field is nonzero. Single precision uses operand bits 30:23 for the exponent and 22:0 for the fraction. Double precision uses bits 62:52 and 51:0. `nan_seen` is 1 exactly when at least one participating operand is a NaN.
- R2: A NaN is signaling when its quiet bit is 0. The quiet bit is bit 22 in single precision and bit 51 in double precision. `invalid` is 1 exactly when at least one participating operand is a signaling NaN.
- R3: With `use_three` = 1, the source of `nan_result` is chosen by the first matching rule in this list:
  - `opd_c` if it is signaling;
  - otherwise `opd_b` if it is signaling;
  - otherwise `opd_a` if it is signaling;
  - otherwise `opd_c` if it is a NaN;
  - otherwise `opd_b` if it is a NaN;
  - otherwise `opd_a`.
- R4: With `use_three` = 0, the source of `nan_result` is chosen by the first matching rule in this list:
  - `opd_b` if it is signaling;
  - otherwise `opd_a` if it is signaling;
  - otherwise `opd_b` if it is a NaN;
  - otherwise `opd_a`.
- R5: When `nan_seen` = 1, `nan_result` equals the chosen operand with its quiet bit forced to 1. Sign, exponent and the rest of the payload are unchanged.
- R6: With `is_double` = 0, operand bits 63:32 are ignored and `nan_result[63:32]` is 0.
- R7: When no participating operand is a NaN, both `nan_seen` and `invalid` are 0. `nan_result` is then the default quiet NaN: 0x7FFFFFFF in single precision, or 0x7FFFFFFFFFFFFFFF in double precision.
- R8: With `use_three` = 0, the value of `opd_c` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 64 | First operand (single precision in bits 31:0) |
| opd_b | input | 64 | Second operand |
| opd_c | input | 64 | Third operand, used only when `use_three` = 1 |
| use_three | input | 1 | 1 selects three-operand priority, 0 selects two-operand priority |
| is_double | input | 1 | 1 selects double precision, 0 selects single precision |
| nan_result | output | 64 | Quieted NaN to return, or the default quiet NaN |
| nan_seen | output | 1 | Some participating operand is a NaN |
| invalid | output | 1 | Some participating operand is a signaling NaN |

## Verification
The hardest cases to reach are those where the priority list must skip over several NaNs at once. Examples are a quiet NaN in `opd_c` losing to a signaling NaN in `opd_a`, or two signaling NaNs competing. Uniform random operands almost never hit these, because a random bit pattern is rarely a NaN. The stimulus therefore draws each operand from weighted classes: ordinary number, infinity, quiet NaN and signaling NaN, with random sign and payload. It also fills the ignored upper half and `opd_c` with signaling NaNs, to expose any leakage in single-precision and two-operand modes.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;
    localparam int WORD_W   = 64;
    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int DP_EXP_W = 11;
    localparam int SP_FRC_W = SP_W - 1 - SP_EXP_W;       // 23
    localparam int DP_FRC_W = WORD_W - 1 - DP_EXP_W;     // 52
    localparam int SP_QBIT  = SP_FRC_W - 1;              // 22
    localparam int DP_QBIT  = DP_FRC_W - 1;              // 51
    localparam int N_OPD    = 3;

    localparam logic [WORD_W-1:0] SP_DEFAULT = {{(WORD_W-SP_W){1'b0}}, 1'b0, {(SP_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] DP_DEFAULT = {1'b0, {(WORD_W-1){1'b1}}};

    typedef enum logic [1:0] {
        PICK_A   = 2'd0,
        PICK_B   = 2'd1,
        PICK_C   = 2'd2,
        PICK_DEF = 2'd3
    } pick_e;
endpackage

// File: rtl/nan_sel_classify.sv
module nan_sel_classify
    import nan_sel_pkg::*;
(
    input  logic [WORD_W-1:0] opd,
    input  logic              is_double,
    output logic              is_nan,
    output logic              is_sig
);
    logic [SP_W-1:0]   sp_shl;
    logic [WORD_W-1:0] dp_shl;
    logic              sp_nan, dp_nan, sp_sig, dp_sig;

    always_comb begin
        sp_shl = {opd[SP_W-2:0], 1'b0};
        dp_shl = {opd[WORD_W-2:0], 1'b0};
        sp_nan = sp_shl > {{SP_EXP_W{1'b1}}, {(SP_W-SP_EXP_W){1'b0}}};
        dp_nan = dp_shl > {{DP_EXP_W{1'b1}}, {(WORD_W-DP_EXP_W){1'b0}}};
        sp_sig = (opd[SP_W-2:SP_QBIT] == {{SP_EXP_W{1'b1}}, 1'b0}) && (opd[SP_QBIT-1:0] != '0);
        dp_sig = (opd[WORD_W-2:DP_QBIT] == {{DP_EXP_W{1'b1}}, 1'b0}) && (opd[DP_QBIT-1:0] != '0);
        is_nan = is_double ? dp_nan : sp_nan;
        is_sig = is_double ? dp_sig : sp_sig;
    end

    always_comb begin
        if (is_sig) begin
            p_sig_is_nan_r2: assert (is_nan);
        end
    end
endmodule

// File: rtl/nan_sel_pick.sv
module nan_sel_pick
    import nan_sel_pkg::*;
(
    input  logic [N_OPD-1:0] nan_v,
    input  logic [N_OPD-1:0] sig_v,
    input  logic             use_three,
    output pick_e            pick
);
    always_comb begin
        if (use_three) begin
            if      (sig_v[2]) pick = PICK_C;
            else if (sig_v[1]) pick = PICK_B;
            else if (sig_v[0]) pick = PICK_A;
            else if (nan_v[2]) pick = PICK_C;
            else if (nan_v[1]) pick = PICK_B;
            else if (nan_v[0]) pick = PICK_A;
            else               pick = PICK_DEF;
        end else begin
            if      (sig_v[1]) pick = PICK_B;
            else if (sig_v[0]) pick = PICK_A;
            else if (nan_v[1]) pick = PICK_B;
            else if (nan_v[0]) pick = PICK_A;
            else               pick = PICK_DEF;
        end
    end

    always_comb begin
        if (pick == PICK_C) begin
            p_c_only_three_r8: assert (use_three);
        end
    end
endmodule

// File: rtl/nan_select_unit.sv
module nan_select_unit
    import nan_sel_pkg::*;
(
    input  logic [63:0] opd_a,
    input  logic [63:0] opd_b,
    input  logic [63:0] opd_c,
    input  logic        use_three,
    input  logic        is_double,
    output logic [63:0] nan_result,
    output logic        nan_seen,
    output logic        invalid
);
    logic [WORD_W-1:0] opd_v  [N_OPD];
    logic [WORD_W-1:0] cand_v [N_OPD];
    logic [N_OPD-1:0]  nan_raw, sig_raw, part_v, nan_v, sig_v;
    logic [WORD_W-1:0] chosen;
    pick_e             pick;

    assign opd_v[0] = opd_a;
    assign opd_v[1] = opd_b;
    assign opd_v[2] = opd_c;
    assign part_v   = {use_three, 1'b1, 1'b1};
    assign nan_v    = nan_raw & part_v;
    assign sig_v    = sig_raw & part_v;

    for (genvar i = 0; i < N_OPD; i++) begin : g_opd
        nan_sel_classify u_cls (
            .opd       (opd_v[i]),
            .is_double (is_double),
            .is_nan    (nan_raw[i]),
            .is_sig    (sig_raw[i])
        );
        // double precision: every candidate is quieted ahead of selection
        assign cand_v[i] = is_double ? (opd_v[i] | (WORD_W'(1) << DP_QBIT)) : opd_v[i];
    end

    nan_sel_pick u_pick (
        .nan_v     (nan_v),
        .sig_v     (sig_v),
        .use_three (use_three),
        .pick      (pick)
    );

    always_comb begin
        unique case (pick)
            PICK_A:  chosen = cand_v[0];
            PICK_B:  chosen = cand_v[1];
            PICK_C:  chosen = cand_v[2];
            default: chosen = is_double ? DP_DEFAULT : SP_DEFAULT;
        endcase
        if (is_double)
            nan_result = chosen;
        else
            // single precision: quiet after selection, upper half cleared
            nan_result = {{(WORD_W-SP_W){1'b0}}, chosen[SP_W-1:0] | (SP_W'(1) << SP_QBIT)};
        nan_seen = |nan_v;
        invalid  = |sig_v;
    end

    always_comb begin
        if (invalid) begin
            p_inv_needs_nan_r2: assert (nan_seen);
        end
        if (!nan_seen) begin
            p_default_out_r7: assert (nan_result == (is_double ? DP_DEFAULT : SP_DEFAULT));
        end
        if (nan_seen && is_double) begin
            p_quiet_dp_r5: assert (nan_result[DP_QBIT] && (&nan_result[WORD_W-2:DP_FRC_W]));
        end
        if (nan_seen && !is_double) begin
            p_quiet_sp_r5: assert (nan_result[SP_QBIT] && (&nan_result[SP_W-2:SP_FRC_W]));
        end
        if (!is_double) begin
            p_upper_zero_r6: assert (nan_result[WORD_W-1:SP_W] == '0);
        end
    end
endmodule

// File: tb/test_nan_select_unit.sv
module test_nan_select_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opd_a = '0, opd_b = '0, opd_c = '0;
    logic        use_three = 1'b0, is_double = 1'b0;
    logic [63:0] nan_result;
    logic        nan_seen, invalid;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nan_select_unit i_nan_select_unit (
        .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c),
        .use_three(use_three), .is_double(is_double),
        .nan_result(nan_result), .nan_seen(nan_seen), .invalid(invalid)
    );

    // behavioural reference: field extraction, then a walk through a priority list
    function automatic bit m_nan(input logic [63:0] v, input bit dp);
        if (dp) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit m_sig(input logic [63:0] v, input bit dp);
        if (dp) return m_nan(v, dp) && !v[51];
        return m_nan(v, dp) && !v[22];
    endfunction

    function automatic void model(input logic [63:0] a, b, c, input bit three, dp,
                                  output logic [63:0] r, output bit nn, output bit iv);
        logic [63:0] ops [3];
        int order [3];
        int cnt;
        int hit;
        ops[0] = a; ops[1] = b; ops[2] = c;
        if (three) begin order[0] = 2; order[1] = 1; order[2] = 0; cnt = 3; end
        else       begin order[0] = 1; order[1] = 0; order[2] = 0; cnt = 2; end
        hit = -1; nn = 0; iv = 0;
        for (int k = 0; k < cnt; k++) begin
            if (m_sig(ops[order[k]], dp)) begin iv = 1; if (hit < 0) hit = order[k]; end
        end
        for (int k = 0; k < cnt; k++) begin
            if (m_nan(ops[order[k]], dp)) begin nn = 1; if (hit < 0) hit = order[k]; end
        end
        if (hit < 0) r = dp ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        else if (dp) r = ops[hit] | (64'd1 << 51);
        else         r = {32'h0, ops[hit][31:0] | 32'h0040_0000};
    endfunction

    task automatic apply_check(input logic [63:0] a, b, c, input bit three, dp, input string tag);
        logic [63:0] er;
        bit en, ei;
        @(posedge clk);
        opd_a = a; opd_b = b; opd_c = c; use_three = three; is_double = dp;
        @(negedge clk);
        model(a, b, c, three, dp, er, en, ei);
        n_vec++;
        if (nan_result !== er || nan_seen !== en || invalid !== ei) begin
            n_fail++;
            $display("FAIL %s: got result=%h seen=%b inv=%b expected result=%h seen=%b inv=%b (a=%h b=%h c=%h three=%b dp=%b)",
                     tag, nan_result, nan_seen, invalid, er, en, ei, a, b, c, three, dp);
        end
    endtask

    // weighted operand classes: 0 number, 1 infinity, 2 quiet NaN, 3 signaling NaN
    function automatic logic [63:0] gen(input bit dp, input int kind);
        logic [63:0] v;
        v = {$urandom, $urandom};
        if (dp) begin
            case (kind)
                0: if (v[62:52] == 11'h7FF) v[62] = 1'b0;
                1: begin v[62:52] = 11'h7FF; v[51:0] = '0; end
                2: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
                default: begin v[62:52] = 11'h7FF; v[51] = 1'b0; if (v[50:0] == 0) v[0] = 1'b1; end
            endcase
        end else begin
            case (kind)
                0: if (v[30:23] == 8'hFF) v[30] = 1'b0;
                1: begin v[30:23] = 8'hFF; v[22:0] = '0; end
                2: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
                default: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 0) v[0] = 1'b1; end
            endcase
        end
        return v;
    endfunction

    localparam logic [63:0] DQ = 64'h7FF8_0000_0000_1234;
    localparam logic [63:0] DS = 64'hFFF0_0000_0000_0ABC;
    localparam logic [63:0] DN = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] SQ = 64'h0000_0000_7FC0_0011;
    localparam logic [63:0] SS = 64'h0000_0000_FF80_0022;
    localparam logic [63:0] SN = 64'h0000_0000_3F80_0000;

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time idle inputs: all-zero operands are not NaN (R7)
        apply_check('0, '0, '0, 1'b0, 1'b0, "R7 idle");
        apply_check(DN, DN, DN, 1'b1, 1'b1, "R7 dp numbers");
        apply_check(64'h7FF0_0000_0000_0000, DN, DN, 1'b1, 1'b1, "R1 dp infinity not NaN");
        apply_check(SN, 64'h0000_0000_7F80_0000, SN, 1'b0, 1'b0, "R1 sp infinity not NaN");
        apply_check(DQ, DN, DN, 1'b0, 1'b1, "R1 dp quiet in a");
        apply_check(SN, SS, SN, 1'b0, 1'b0, "R2 sp signaling raises invalid");
        apply_check(DS, DQ, DQ, 1'b1, 1'b1, "R3 signaling a beats quiet c");
        apply_check(DS, DS ^ 64'h1, DS ^ 64'h2, 1'b1, 1'b1, "R3 signaling c wins");
        apply_check(DQ, DQ ^ 64'h5, DN, 1'b1, 1'b1, "R3 quiet b over quiet a");
        apply_check(SS, SQ, SN, 1'b0, 1'b0, "R4 signaling a beats quiet b");
        apply_check(SQ, SQ ^ 64'h7, SN, 1'b0, 1'b0, "R4 quiet b over quiet a");
        apply_check(DS, DN, DN, 1'b0, 1'b1, "R5 dp payload kept quiet forced");
        apply_check(SS | 64'hFFF0_0000_0000_0000, SN | 64'h7FF8_0000_0000_0000, SN, 1'b0, 1'b0, "R6 upper half ignored");
        apply_check(DN, DN, DS, 1'b0, 1'b1, "R8 signaling c ignored dp");
        apply_check(SQ, SN, SS, 1'b0, 1'b0, "R8 signaling c ignored sp");
        apply_check(SN, SN, SS, 1'b0, 1'b0, "R8 lone c ignored");

        for (int n = 0; n < N_RAND; n++) begin
            bit dp, th;
            logic [63:0] a, b, c;
            dp = $urandom_range(1, 0) == 1;
            th = $urandom_range(1, 0) == 1;
            a = gen(dp, $urandom_range(3, 0));
            b = gen(dp, $urandom_range(3, 0));
            c = gen(dp, $urandom_range(3, 0));
            apply_check(a, b, c, th, dp, th ? "R3/R5 random" : "R4/R8 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule